// File: doc/BRIEF.md
# Serial Management Frame Master

This block drives clause-22 management frames from a MAC towards its PHYs. Software writes a single 32-bit command word. If the port is enabled and no frame is running, the block shifts out a 32-bit preamble of ones and then the 32 command bits, MSB first, on the serial data line. A divided copy of the system clock is driven as the management clock.

For a read operation, the block stops driving the data line for the turnaround and data bits. It then captures the 16 data bits that the PHY returns into the low half of the command word. An idle flag is high whenever no frame is in progress. Software polls this flag before reading back the result.

The management clock rate is set by a 2-bit divider select, which the block captures at the start of each frame.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `cmd_rdata` is all zeros.
- R2: A `cmd_wr` pulse seen with `mgmt_en`=1 while `idle`=1 starts a frame. `idle` reads 0 from the next cycle, and `cmd_rdata` shows the written word once the frame ends.
- R3: A `cmd_wr` pulse seen with `mgmt_en`=0 is ignored. `idle` stays 1 and `cmd_rdata` keeps its previous value.
- R4: A `cmd_wr` pulse seen while a frame is running is ignored. The frame continues unchanged, and `cmd_rdata` at its end reflects only the first word.
- R5: A frame consists of 64 bit periods. Periods 0..31 drive 1 on `mdio_o`. Period 32+k drives bit (31-k) of the command word. `mdio_o` changes only when `mdc` falls.
- R6: With divider select S (0..3), the half-period of `mdc` is 4<<S system clocks, giving divide-by 8, 16, 32 or 64. `mdc` rises for the first time 4<<S clocks after the frame starts, and it is 0 whenever the block is idle.
- R7: The command word has these fields: bits 31:30 start code, bits 29:28 operation (10 = read, 01 = write), bits 27:23 PHY address, bits 22:18 register address, bits 17:16 turnaround code, bits 15:0 data. For a read, `mdio_oe` is 0 from period 46 (the turnaround) to the end of the frame. For a write, `mdio_oe` is 1 for all 64 periods.
- R8: During a read, `mdio_i` is sampled on each rising `mdc` edge of periods 48..63, MSB first. When the frame ends, `cmd_rdata[15:0]` holds the sampled value and bits 31:16 hold the issued word.
- R9: `idle` returns to 1 exactly 128·(4<<S) clocks after the start, on the final falling `mdc` edge.
- R10: A change of the divider select during a frame has no effect until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | 2 | Clock divider select (0..3 gives /8, /16, /32, /64) |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command word readback, with read data in bits 15:0 |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the serial data line |
| mdio_i | input | 1 | Serial data in |

## Verification
The bench compares every clock against a timing model at all four divider settings. An off-by-one in the half-period counter would therefore show up as a shifted `mdc` edge, and a mis-counted frame length would show up as `idle` rising early or late. Three more corner cases are targeted:
- A second command is written mid-frame. A design that lets it through would restart or corrupt the shift sequence.
- A command is written with the port disabled. A design that accepts it would drop `idle`.
- The divider select is changed mid-frame. A design that does not capture it would shift `mdc` timing in the middle of a frame.

The PHY model drives a distinct pattern only during the data periods. Sampling on the wrong edge, or releasing the line late, would leave a shifted or corrupted value in the returned field.

// File: rtl/mdio_pkg.sv
// Package: shared constants for the serial management frame master.
// Assumes clause-22 framing: 32 preamble bits followed by a 32-bit word.
package mdio_pkg;
    localparam int WORD_W    = 32;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + WORD_W;
    localparam int OP_HI     = 29;
    localparam int OP_LO     = 28;
    localparam int DATA_W    = 16;
    // Bit period at which the turnaround begins, and the first data period.
    localparam int TA_START  = PRE_LEN + (WORD_W - 1 - 17);
    localparam int RD_START  = TA_START + 2;
    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
// Module: management clock divider.
// Does: while run is high, toggles mdc every (BASE_HALF << sel) clocks and
// flags on the toggling clock whether the edge is a rise or a fall.
// Assumes: sel is held stable by the caller for the whole frame.
module mdio_clkgen #(
    parameter int BASE_HALF = 4,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam int MAX_HALF = BASE_HALF << ((1 << SEL_W) - 1);
    localparam int CNT_W    = $clog2(MAX_HALF);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;
    logic             hit;

    // Terminal count for the selected half-period.
    always_comb begin
        term = CNT_W'((BASE_HALF << sel) - 1);
        hit  = run && (cnt == term);
    end

    assign rise_stb = hit && !mdc;
    assign fall_stb = hit && mdc;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (hit) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_framer.sv
// Module: frame sequencer.
// Does: accepts a command word, shifts out the preamble and the word,
// releases the line for read turnaround and data, and captures read data.
// Assumes: rise_stb and fall_stb come from a divider gated by busy.
module mdio_framer
    import mdio_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic [SEL_W-1:0]  sel_q,
    output logic [WORD_W-1:0] word,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int IDX_W = $clog2(FRAME_LEN);

    logic [FRAME_LEN-1:0] shreg;
    logic [IDX_W-1:0]     bit_idx;
    logic                 is_read;

    // Frame launch, bit advance on falling mdc, read capture on rising mdc.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            shreg   <= '0;
            bit_idx <= '0;
            is_read <= 1'b0;
            word    <= '0;
            sel_q   <= '0;
        end else if (!busy) begin
            if (cmd_wr && en) begin
                busy    <= 1'b1;
                shreg   <= {{PRE_LEN{1'b1}}, cmd_in};
                bit_idx <= '0;
                is_read <= (cmd_in[OP_HI:OP_LO] == OP_READ);
                word    <= cmd_in;
                sel_q   <= sel_in;
            end
        end else begin
            if (rise_stb && is_read && (bit_idx >= IDX_W'(RD_START)))
                word[DATA_W-1:0] <= {word[DATA_W-2:0], mdio_i};
            if (fall_stb) begin
                shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
                if (bit_idx == IDX_W'(FRAME_LEN - 1))
                    busy <= 1'b0;
            end
        end
    end

    // Line drive: the top shift bit, released during read turnaround/data.
    always_comb begin
        mdio_o  = shreg[FRAME_LEN-1];
        mdio_oe = busy && !(is_read && (bit_idx >= IDX_W'(TA_START)));
    end

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && en) |=> busy);
    // R3
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en) |=> !busy);
    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !is_read) |=> $stable(word));
    // R5
    preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (bit_idx < IDX_W'(PRE_LEN))) |-> mdio_o);
    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_read && (bit_idx >= IDX_W'(RD_START))) |-> !mdio_oe);
    // R10
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sel_q));
endmodule

// File: rtl/mdio_mgmt_engine.sv
// Module: top of the serial management frame master.
// Does: joins the frame sequencer and the clock divider; idle is the
// inverse of the sequencer's busy state.
// Assumes: mdio_i is already synchronised to clk.
module mdio_mgmt_engine
    import mdio_pkg::*;
#(
    parameter int BASE_HALF = 4,
    parameter int SEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_en,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic [WORD_W-1:0] cmd_rdata,
    output logic              idle,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic             busy;
    logic             rise_stb;
    logic             fall_stb;
    logic [SEL_W-1:0] sel_q;

    mdio_framer #(.SEL_W(SEL_W)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mgmt_en),
        .cmd_wr   (cmd_wr),
        .cmd_in   (cmd_wdata),
        .sel_in   (div_sel),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .sel_q    (sel_q),
        .word     (cmd_rdata),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    mdio_clkgen #(.BASE_HALF(BASE_HALF), .SEL_W(SEL_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .sel      (sel_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    assign idle = !busy;

    // R9
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> !mdc);
endmodule

// File: tb/tb_mdio_mgmt_engine.sv
module tb_mdio_mgmt_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_en = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #2 clk = ~clk;

    mdio_mgmt_engine dut (
        .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .div_sel(div_sel),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Behavioural model state.
    bit          m_busy = 0;
    bit          m_read = 0;
    int          m_t = 0;
    int          m_h = 4;
    logic [31:0] m_cmd = '0;
    logic [31:0] m_reg = '0;
    logic [15:0] reply = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] rg, input logic [15:0] d);
        return {2'b01, op, phy, rg, 2'b10, d};
    endfunction

    // One clock: compare at the falling edge, drive inputs, advance the model.
    task automatic tick(input logic wr, input logic [31:0] d, input logic en, input logic [1:0] sel);
        int b;
        logic e_oe;
        @(negedge clk);
        b = m_t / (2 * m_h);
        e_oe = m_busy && !(m_read && b >= 46);
        chk("R6 mdc", {31'd0, mdc}, {31'd0, m_busy && ((m_t / m_h) % 2 == 1)});
        chk("R9 idle", {31'd0, idle}, {31'd0, !m_busy});
        chk("R7 mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
        if (e_oe)
            chk("R5 mdio_o", {31'd0, mdio_o}, {31'd0, (b < 32) ? 1'b1 : m_cmd[63 - b]});
        if (!m_busy)
            chk("R8 cmd_rdata", cmd_rdata, m_reg);
        cmd_wr    = wr;
        cmd_wdata = d;
        mgmt_en   = en;
        div_sel   = sel;
        mdio_i    = (m_busy && m_read && b >= 48) ? reply[63 - b] : 1'b1;
        if (m_busy) begin
            m_t++;
            if (m_t == 128 * m_h) begin
                m_busy = 0;
                if (m_read) m_reg[15:0] = reply;
            end
        end else if (wr && en) begin
            m_busy = 1; m_t = 0; m_h = 4 << sel;
            m_cmd = d; m_reg = d; m_read = (d[29:28] == 2'b10);
        end
    endtask

    initial begin
        logic [31:0] w1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 idle", {31'd0, idle}, 32'd1);
        chk("R1 mdc", {31'd0, mdc}, 32'd0);
        chk("R1 mdio_oe", {31'd0, mdio_oe}, 32'd0);
        chk("R1 cmd_rdata", cmd_rdata, 32'd0);
        rst_n = 1'b1;
        tick(0, 0, 1, 0);
        tick(0, 0, 1, 0);

        // R2 write frame at divide-by-8, with an R4 mid-frame write.
        w1 = mk(2'b01, 5'h0B, 5'h04, 16'hBEEF);
        tick(1, w1, 1, 0);
        tick(0, 0, 1, 0);
        chk("R2 idle low after start", {31'd0, idle}, 32'd0);
        for (int i = 0; i < 530; i++)
            if (i == 100) tick(1, mk(2'b10, 5'h01, 5'h02, 16'h1111), 1, 0);
            else tick(0, 0, 1, 0);
        chk("R4 busy write ignored", cmd_rdata, w1);
        chk("R9 idle after write", {31'd0, idle}, 32'd1);

        // R8 read at divide-by-16, select changed mid-frame (R10).
        reply = 16'hA5C3;
        tick(1, mk(2'b10, 5'h1F, 5'h01, 16'h0000), 1, 1);
        for (int i = 0; i < 1060; i++) tick(0, 0, 1, (i < 200) ? 2'd1 : 2'd3);
        chk("R8 read data", {16'd0, cmd_rdata[15:0]}, 32'h0000A5C3);
        chk("R10 frame length kept", {31'd0, idle}, 32'd1);

        // R3 disabled write ignored.
        w1 = cmd_rdata;
        tick(1, mk(2'b01, 5'h02, 5'h03, 16'h5555), 0, 2);
        for (int i = 0; i < 10; i++) tick(0, 0, 0, 2);
        chk("R3 idle stays", {31'd0, idle}, 32'd1);
        chk("R3 word unchanged", cmd_rdata, w1);

        // R8 read at divide-by-64, then R5 write at divide-by-32.
        reply = 16'h1234;
        tick(1, mk(2'b10, 5'h05, 5'h1E, 16'hFFFF), 1, 3);
        for (int i = 0; i < 4110; i++) tick(0, 0, 1, 3);
        chk("R8 read data slow", {16'd0, cmd_rdata[15:0]}, 32'h00001234);
        w1 = mk(2'b01, 5'h15, 5'h0A, 16'h6A59);
        tick(1, w1, 1, 2);
        for (int i = 0; i < 2060; i++) tick(0, 0, 1, 2);
        chk("R5 write word readback", cmd_rdata, w1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule